// File: doc/BRIEF.md
# Linked-List Memory-to-Stream DMA Engine

This block is the transmit half of one DMA channel. Software builds a chain of data descriptors in memory and gives the engine the address of the first one. The engine reads each descriptor, streams the bytes of the buffer it names to a client one byte per handshake, and then closes the descriptor. Closing means an optional interrupt pulse, a write of the four descriptor words back to where they came from, and then either a move to the next descriptor or a halt at the end of the list.

A descriptor is four consecutive 32-bit words at a word-aligned address. Offset +0 is the next-descriptor pointer, +4 the first buffer byte, +8 the flag word and +12 the buffer end (one past the last byte). Progress is a current byte pointer that starts at the buffer start and is compared with the buffer end. Data moves in steps of at most `STEP_MAX` bytes, and a step begins only while the register block reports the channel as running. A halted channel can be restarted at a new chain, or continued: the engine re-reads the descriptor it stopped on and follows its next pointer if software has cleared the end-of-list flag since.

Top module: `dma_out_engine`

## Requirements
- R1: While `rst_n` is low and after it is released, `st_valid_o`, `st_last_o`, `mem_rd_o`, `mem_wr_o`, `irq_o` and `eol_o` are low until a start is given.
- R2: A start reads the four descriptor words at the start address, at offsets +0, +4, +8 and +12 in that order. It then streams every byte from the buffer start (word +4) up to but not including the buffer end (word +12), in ascending address order.
- R3: Buffer memory is read as word-aligned 32-bit words. Bytes are taken little-endian: byte address a is bits [8*(a mod 4)+7 : 8*(a mod 4)] of the word at a rounded down to a multiple of 4. Buffer start and end may have any alignment.
- R4: A step moves at most `STEP_MAX` bytes. A new step, and the closing of a finished descriptor, begins only while `run_i` is high. A step already begun finishes even if `run_i` falls.
- R5: `st_last_o` is high on the final byte of a descriptor whose flag bit 3 is set, and is never high on any other beat.
- R6: When a descriptor finishes, `irq_o` pulses high for exactly one cycle if its flag bit 4 is set, and stays low otherwise.
- R7: After the final byte, the four descriptor words are written back unchanged, in the order +0, +4, +8, +12, to the descriptor's own address. Each write is held until `mem_wack_i`, and the flag bits the engine does not act on (including 5, 11 and 31:16) are preserved.
- R8: If flag bit 0 is set, `eol_o` rises after the write-back, and no byte is streamed and no memory is read until a start or a continue.
- R9: If flag bit 0 is clear, the descriptor named by word +0 is loaded next and streaming carries on with no gap in byte order.
- R10: A descriptor whose buffer start equals its buffer end streams no byte but is still closed (interrupt, write-back, chain).
- R11: A `cont_i` pulse while halted re-reads the current descriptor without writing it. If its flag bit 0 is now clear, `eol_o` falls and the descriptor named by its word +0 is loaded and run. Otherwise the engine stays halted with `eol_o` high.
- R12: `start_i` is acted on only while idle or halted; a start during a transfer has no effect on the stream.
- R13: While `st_valid_o` is high and `st_ready_i` is low, `st_valid_o`, `st_data_o` and `st_last_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Channel is in the running state (from register block) |
| start_i | input | 1 | Pulse: begin a new chain at `start_desc_i` |
| start_desc_i | input | AW | Address of the first descriptor |
| cont_i | input | 1 | Pulse: re-examine the halted descriptor |
| mem_rd_o | output | 1 | Read request, held until `mem_rvalid_i` |
| mem_raddr_o | output | AW | Word-aligned read byte address |
| mem_rvalid_i | input | 1 | Read data valid; completes the request |
| mem_rdata_i | input | 32 | Read data |
| mem_wr_o | output | 1 | Write request, held until `mem_wack_i` |
| mem_waddr_o | output | AW | Write byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_wack_i | input | 1 | Write accepted |
| st_valid_o | output | 1 | Stream byte valid |
| st_data_o | output | 8 | Stream byte |
| st_last_o | output | 1 | Final byte of a packet |
| st_ready_i | input | 1 | Client accepts the byte |
| irq_o | output | 1 | One-cycle interrupt pulse on descriptor completion |
| eol_o | output | 1 | Channel halted at end of list |

## Verification
A single descriptor that is aligned at both ends checks the basic byte order, the last marker and the write-back. A three-descriptor chain, with unaligned starts and ends, an empty middle descriptor and a stuttering client, separates correct lane selection and word refetch from off-by-one pointer errors. It also shows whether an empty buffer is still closed and chained. Continue is tried twice on the same halted descriptor, once with its end-of-list bit still set and once cleared, to tell a re-read that resumes from one that blindly restarts. A long buffer run with `run_i` low, and then dropped during the first byte, shows that the engine idles and stops at a step boundary and not at some other count.

// File: rtl/dout_pkg.sv
// Shared constants and types for the memory-to-stream DMA engine.
// Assumes 32-bit memory words and four-word data descriptors.
package dout_pkg;
    localparam int WORD_W     = 32;
    localparam int LANES      = WORD_W / 8;
    localparam int LANE_W     = $clog2(LANES);
    localparam int DESC_WORDS = 4;

    // Word index inside a descriptor; the order is the memory layout.
    localparam logic [1:0] IDX_NEXT  = 2'd0;
    localparam logic [1:0] IDX_START = 2'd1;
    localparam logic [1:0] IDX_FLAGS = 2'd2;
    localparam logic [1:0] IDX_END   = 2'd3;

    // Flag bits the engine acts on.
    localparam int FLAG_EOL = 0;
    localparam int FLAG_EOP = 3;
    localparam int FLAG_IRQ = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_CHECK,
        ST_FETCH,
        ST_SEND,
        ST_WBACK,
        ST_PARK,
        ST_RELOAD
    } dout_state_e;
endpackage

// File: rtl/dout_desc_file.sv
// Holds the four words of the current descriptor.
// Written one word per read beat; one word is read out by index for
// write-back. The decoded pointers and the flag bits are always presented.
module dout_desc_file
    import dout_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        idx_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic [WORD_W-1:0] rd_word_o,
    output logic [AW-1:0]     next_o,
    output logic [AW-1:0]     end_o,
    output logic              eol_f_o,
    output logic              eop_f_o,
    output logic              irq_f_o
);
    logic [WORD_W-1:0] words_q [DESC_WORDS];

    // Capture a descriptor word as it arrives from memory.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DESC_WORDS; i++) words_q[i] <= '0;
        end else if (wr_en_i) begin
            words_q[idx_i] <= wr_data_i;
        end
    end

    // Decode fields and the indexed word for write-back.
    assign rd_word_o = words_q[idx_i];
    assign next_o    = words_q[IDX_NEXT][AW-1:0];
    assign end_o     = words_q[IDX_END][AW-1:0];
    assign eol_f_o   = words_q[IDX_FLAGS][FLAG_EOL];
    assign eop_f_o   = words_q[IDX_FLAGS][FLAG_EOP];
    assign irq_f_o   = words_q[IDX_FLAGS][FLAG_IRQ];
endmodule

// File: rtl/dout_lane_sel.sv
// Picks one byte out of a memory word, little-endian lane order.
// Assumes the lane index is already within range.
module dout_lane_sel
    import dout_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [LANE_W-1:0] lane_i,
    output logic [7:0]        byte_o
);
    logic [7:0] lane_bytes [LANES];

    // Split the word into its byte lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_bytes[g] = word_i[8*g +: 8];
    end

    // Select the addressed lane.
    assign byte_o = lane_bytes[lane_i];
endmodule

// File: rtl/dout_ctrl.sv
// Sequencer of the engine: descriptor load, stepwise byte streaming,
// completion (interrupt, write-back) and chaining, halt and continue.
// Assumes descriptor addresses are word aligned and buffer end is reachable
// from buffer start by incrementing (start <= end).
module dout_ctrl
    import dout_pkg::*;
#(
    parameter int AW       = 32,
    parameter int STEP_MAX = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              start_i,
    input  logic [AW-1:0]     start_desc_i,
    input  logic              cont_i,
    output logic              mem_rd_o,
    output logic [AW-1:0]     mem_raddr_o,
    input  logic              mem_rvalid_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              mem_wr_o,
    output logic [AW-1:0]     mem_waddr_o,
    input  logic              mem_wack_i,
    output logic              st_valid_o,
    output logic              st_last_o,
    input  logic              st_ready_i,
    output logic              irq_o,
    output logic              eol_o,
    output logic              dwr_en_o,
    output logic [1:0]        idx_o,
    output logic [WORD_W-1:0] word_o,
    output logic [LANE_W-1:0] lane_o,
    input  logic [AW-1:0]     next_i,
    input  logic [AW-1:0]     end_i,
    input  logic              eol_f_i,
    input  logic              eop_f_i,
    input  logic              irq_f_i
);
    localparam int STEP_W = $clog2(STEP_MAX + 1);

    dout_state_e       state_q;
    logic [AW-1:0]     cur_q;
    logic [AW-1:0]     desc_q;
    logic [1:0]        idx_q;
    logic [WORD_W-1:0] word_q;
    logic [STEP_W-1:0] step_q;
    logic              eol_q;
    logic              irq_q;

    logic [AW-1:0] cur_nx;
    logic [AW-1:0] desc_off;
    logic          at_end;
    logic          step_done;

    // Next-byte pointer, descriptor word address and step-end detection.
    always_comb begin
        cur_nx    = cur_q + AW'(1);
        desc_off  = desc_q + AW'({idx_q, 2'b00});
        at_end    = (cur_q == end_i);
        step_done = (cur_nx == end_i) || (step_q == STEP_W'(STEP_MAX - 1));
    end

    // Main sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= '0;
            desc_q  <= '0;
            idx_q   <= '0;
            word_q  <= '0;
            step_q  <= '0;
            eol_q   <= 1'b0;
            irq_q   <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            unique case (state_q)
                ST_IDLE, ST_PARK: begin
                    if (start_i) begin
                        desc_q  <= start_desc_i;
                        idx_q   <= IDX_NEXT;
                        eol_q   <= 1'b0;
                        state_q <= ST_LOAD;
                    end else if (cont_i && state_q == ST_PARK) begin
                        idx_q   <= IDX_NEXT;
                        state_q <= ST_RELOAD;
                    end
                end
                ST_LOAD: begin
                    if (mem_rvalid_i) begin
                        if (idx_q == IDX_START) cur_q <= mem_rdata_i[AW-1:0];
                        idx_q <= idx_q + 2'd1;
                        if (idx_q == IDX_END) state_q <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (run_i) begin
                        step_q <= '0;
                        if (at_end) begin
                            irq_q   <= irq_f_i;
                            idx_q   <= IDX_NEXT;
                            state_q <= ST_WBACK;
                        end else begin
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_rvalid_i) begin
                        word_q  <= mem_rdata_i;
                        state_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (st_ready_i) begin
                        cur_q  <= cur_nx;
                        step_q <= step_q + STEP_W'(1);
                        if (step_done) state_q <= ST_CHECK;
                        else if (cur_q[LANE_W-1:0] == {LANE_W{1'b1}}) state_q <= ST_FETCH;
                    end
                end
                ST_WBACK: begin
                    if (mem_wack_i) begin
                        idx_q <= idx_q + 2'd1;
                        if (idx_q == IDX_END) begin
                            if (eol_f_i) begin
                                eol_q   <= 1'b1;
                                state_q <= ST_PARK;
                            end else begin
                                desc_q  <= next_i;
                                state_q <= ST_LOAD;
                            end
                        end
                    end
                end
                ST_RELOAD: begin
                    if (mem_rvalid_i) begin
                        idx_q <= idx_q + 2'd1;
                        if (idx_q == IDX_END) begin
                            if (eol_f_i) begin
                                state_q <= ST_PARK;
                            end else begin
                                eol_q   <= 1'b0;
                                desc_q  <= next_i;
                                state_q <= ST_LOAD;
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port decode from the state.
    always_comb begin
        mem_rd_o    = (state_q == ST_LOAD) || (state_q == ST_RELOAD) || (state_q == ST_FETCH);
        mem_raddr_o = (state_q == ST_FETCH) ? {cur_q[AW-1:LANE_W], {LANE_W{1'b0}}} : desc_off;
        mem_wr_o    = (state_q == ST_WBACK);
        mem_waddr_o = desc_off;
        st_valid_o  = (state_q == ST_SEND);
        st_last_o   = (state_q == ST_SEND) && eop_f_i && (cur_nx == end_i);
        dwr_en_o    = ((state_q == ST_LOAD) || (state_q == ST_RELOAD)) && mem_rvalid_i;
        irq_o       = irq_q;
        eol_o       = eol_q;
        idx_o       = idx_q;
        word_o      = word_q;
        lane_o      = cur_q[LANE_W-1:0];
    end
endmodule

// File: rtl/dma_out_engine.sv
// Memory-to-stream engine of one DMA channel: walks a chain of four-word
// data descriptors and streams their buffers as bytes to a client.
// Assumes a memory port with one outstanding request at a time.
module dma_out_engine
    import dout_pkg::*;
#(
    parameter int AW       = 32,
    parameter int STEP_MAX = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              start_i,
    input  logic [AW-1:0]     start_desc_i,
    input  logic              cont_i,
    output logic              mem_rd_o,
    output logic [AW-1:0]     mem_raddr_o,
    input  logic              mem_rvalid_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              mem_wr_o,
    output logic [AW-1:0]     mem_waddr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_wack_i,
    output logic              st_valid_o,
    output logic [7:0]        st_data_o,
    output logic              st_last_o,
    input  logic              st_ready_i,
    output logic              irq_o,
    output logic              eol_o
);
    logic              dwr_en;
    logic [1:0]        idx;
    logic [WORD_W-1:0] word;
    logic [LANE_W-1:0] lane;
    logic [AW-1:0]     next_ptr;
    logic [AW-1:0]     end_ptr;
    logic              eol_f;
    logic              eop_f;
    logic              irq_f;

    dout_ctrl #(.AW(AW), .STEP_MAX(STEP_MAX)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run_i),
        .start_i      (start_i),
        .start_desc_i (start_desc_i),
        .cont_i       (cont_i),
        .mem_rd_o     (mem_rd_o),
        .mem_raddr_o  (mem_raddr_o),
        .mem_rvalid_i (mem_rvalid_i),
        .mem_rdata_i  (mem_rdata_i),
        .mem_wr_o     (mem_wr_o),
        .mem_waddr_o  (mem_waddr_o),
        .mem_wack_i   (mem_wack_i),
        .st_valid_o   (st_valid_o),
        .st_last_o    (st_last_o),
        .st_ready_i   (st_ready_i),
        .irq_o        (irq_o),
        .eol_o        (eol_o),
        .dwr_en_o     (dwr_en),
        .idx_o        (idx),
        .word_o       (word),
        .lane_o       (lane),
        .next_i       (next_ptr),
        .end_i        (end_ptr),
        .eol_f_i      (eol_f),
        .eop_f_i      (eop_f),
        .irq_f_i      (irq_f)
    );

    dout_desc_file #(.AW(AW)) u_desc (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (dwr_en),
        .idx_i     (idx),
        .wr_data_i (mem_rdata_i),
        .rd_word_o (mem_wdata_o),
        .next_o    (next_ptr),
        .end_o     (end_ptr),
        .eol_f_o   (eol_f),
        .eop_f_o   (eop_f),
        .irq_f_o   (irq_f)
    );

    dout_lane_sel u_lane (
        .word_i (word),
        .lane_i (lane),
        .byte_o (st_data_o)
    );
endmodule

// File: rtl/dma_out_engine_chk.sv
// Protocol checker for dma_out_engine, attached by bind.
// Assumes word-aligned descriptor addresses.
module dma_out_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd_o,
    input logic [AW-1:0] mem_raddr_o,
    input logic          mem_rvalid_i,
    input logic          mem_wr_o,
    input logic [AW-1:0] mem_waddr_o,
    input logic [31:0]   mem_wdata_o,
    input logic          mem_wack_i,
    input logic          st_valid_o,
    input logic [7:0]    st_data_o,
    input logic          st_last_o,
    input logic          st_ready_i,
    input logic          irq_o,
    input logic          eol_o
);
    p_stream_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid_o && !st_ready_i |=> st_valid_o && $stable(st_data_o) && $stable(st_last_o));

    p_last_in_beat_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_last_o |-> st_valid_o);

    p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    p_parked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        eol_o |-> !st_valid_o && !mem_wr_o);

    p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o && !mem_rvalid_i |=> mem_rd_o && $stable(mem_raddr_o));

    p_wb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o && !mem_wack_i |=> mem_wr_o && $stable(mem_waddr_o) && $stable(mem_wdata_o));

    p_port_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_o && mem_wr_o));

    p_rd_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> mem_raddr_o[1:0] == 2'b00);
endmodule

bind dma_out_engine dma_out_engine_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_rd_o     (mem_rd_o),
    .mem_raddr_o  (mem_raddr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_wr_o     (mem_wr_o),
    .mem_waddr_o  (mem_waddr_o),
    .mem_wdata_o  (mem_wdata_o),
    .mem_wack_i   (mem_wack_i),
    .st_valid_o   (st_valid_o),
    .st_data_o    (st_data_o),
    .st_last_o    (st_last_o),
    .st_ready_i   (st_ready_i),
    .irq_o        (irq_o),
    .eol_o        (eol_o)
);

// File: tb/dma_out_engine_tb.sv
module dma_out_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 32;
    localparam int STEP       = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_desc = '0;
    logic          cont = 1'b0;
    logic          mem_rd;
    logic [AW-1:0] mem_raddr;
    logic          mem_rvalid = 1'b0;
    logic [31:0]   mem_rdata = '0;
    logic          mem_wr;
    logic [AW-1:0] mem_waddr;
    logic [31:0]   mem_wdata;
    logic          mem_wack = 1'b0;
    logic          st_valid;
    logic [7:0]    st_data;
    logic          st_last;
    logic          st_ready = 1'b0;
    logic          irq;
    logic          eol;

    logic [31:0] mem [256];
    logic [8:0]  exp_q [$];
    logic [63:0] exp_wr [$];
    logic [63:0] wr_log [$];
    int checks = 0, errors = 0;
    int irq_cnt = 0, rd_cycles = 0, byte_cnt = 0, cyc = 0;
    int rdy_mode = 0;
    logic rdy_man = 1'b0;
    logic hold_pend = 1'b0;
    logic [8:0] held;

    dma_out_engine #(.AW(AW), .STEP_MAX(STEP)) u_dut (
        .clk(clk), .rst_n(rst_n), .run_i(run), .start_i(start),
        .start_desc_i(start_desc), .cont_i(cont),
        .mem_rd_o(mem_rd), .mem_raddr_o(mem_raddr), .mem_rvalid_i(mem_rvalid),
        .mem_rdata_i(mem_rdata), .mem_wr_o(mem_wr), .mem_waddr_o(mem_waddr),
        .mem_wdata_o(mem_wdata), .mem_wack_i(mem_wack),
        .st_valid_o(st_valid), .st_data_o(st_data), .st_last_o(st_last),
        .st_ready_i(st_ready), .irq_o(irq), .eol_o(eol)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Memory model: one-cycle read and write acknowledge, write log.
    always @(posedge clk) begin
        mem_rvalid <= mem_rd && !mem_rvalid;
        mem_rdata  <= mem[mem_raddr[9:2]];
        mem_wack   <= mem_wr && !mem_wack;
        if (mem_wr && mem_wack) begin
            mem[mem_waddr[9:2]] <= mem_wdata;
            wr_log.push_back({mem_waddr, mem_wdata});
        end
        if (mem_rd) rd_cycles++;
        if (irq) irq_cnt++;
        cyc++;
    end

    // Client ready driver.
    always @(posedge clk) begin
        #1;
        st_ready <= (rdy_mode == 1) ? ((cyc % 3) != 0) : rdy_man;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: scoreboard pop on each accepted byte, hold check on stalls.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend && st_valid)
                chk({st_last, st_data} === held, "R13 stalled beat changed", {st_last, st_data}, held);
            hold_pend = st_valid && !st_ready;
            held = {st_last, st_data};
            if (st_valid && st_ready) begin
                byte_cnt++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R2 R12 unexpected byte", {st_last, st_data}, 0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    chk({st_last, st_data} === e, "R2 R3 R5 byte/last", {st_last, st_data}, e);
                end
            end
        end
    end

    function automatic logic [7:0] byte_at(input int a);
        return mem[a >> 2][8*(a % 4) +: 8];
    endfunction

    task automatic set_byte(input int a, input logic [7:0] v);
        mem[a >> 2][8*(a % 4) +: 8] = v;
    endtask

    task automatic put_desc(input int da, input int nxt, input int s, input logic [31:0] f, input int e);
        mem[(da >> 2) + 0] = 32'(nxt);
        mem[(da >> 2) + 1] = 32'(s);
        mem[(da >> 2) + 2] = f;
        mem[(da >> 2) + 3] = 32'(e);
        for (int a = s; a < e; a++) set_byte(a, 8'((a * 7 + 13) & 255));
    endtask

    // Expected bytes and write-back of the descriptor at da, from memory.
    task automatic expect_desc(input int da);
        int s, e;
        logic [31:0] f;
        s = int'(mem[(da >> 2) + 1]);
        f = mem[(da >> 2) + 2];
        e = int'(mem[(da >> 2) + 3]);
        for (int a = s; a < e; a++) exp_q.push_back({f[3] && (a == e - 1), byte_at(a)});
        for (int i = 0; i < 4; i++) exp_wr.push_back({32'(da + 4*i), mem[(da >> 2) + i]});
    endtask

    task automatic check_wb(input string tag);
        chk(wr_log.size() == exp_wr.size(), tag, wr_log.size(), exp_wr.size());
        for (int i = 0; i < wr_log.size() && i < exp_wr.size(); i++)
            chk(wr_log[i] === exp_wr[i], tag, wr_log[i], exp_wr[i]);
        wr_log.delete();
        exp_wr.delete();
    endtask

    task automatic pulse_start(input int a);
        @(posedge clk); #1;
        start = 1'b1;
        start_desc = AW'(a);
        @(posedge clk); #1;
        start = 1'b0;
    endtask

    task automatic pulse_cont();
        @(posedge clk); #1;
        cont = 1'b1;
        @(posedge clk); #1;
        cont = 1'b0;
    endtask

    task automatic wait_eol(input string tag);
        int n = 0;
        while (!(eol === 1'b1 && exp_q.size() == 0) && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk(n < 3000, tag, n, 0);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "R2 watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int i0, b0, r0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(st_valid === 1'b0 && st_last === 1'b0, "R1 stream idle after reset", st_valid, 0);
        chk(mem_rd === 1'b0 && mem_wr === 1'b0, "R1 memory idle after reset", {mem_rd, mem_wr}, 0);
        chk(eol === 1'b0 && irq === 1'b0, "R1 eol/irq low after reset", {eol, irq}, 0);

        // Single aligned descriptor, all flags, carried metadata bits.
        run = 1'b1;
        rdy_man = 1'b1;
        put_desc('h000, 'h3f0, 'h100, 32'hABCD_0839, 'h108);
        expect_desc('h000);
        i0 = irq_cnt;
        pulse_start('h000);
        wait_eol("R8 single descriptor reaches end of list");
        chk(irq_cnt - i0 == 1, "R6 one irq pulse", irq_cnt - i0, 1);
        check_wb("R7 write-back of single descriptor");
        chk(eol === 1'b1, "R8 eol after list end", eol, 1);
        r0 = rd_cycles; b0 = byte_cnt;
        repeat (40) @(negedge clk);
        chk(rd_cycles == r0 && byte_cnt == b0, "R8 no activity while halted", rd_cycles - r0, 0);

        // Chain: unaligned buffer, empty descriptor, multi-step buffer; stalls.
        put_desc('h010, 'h020, 'h203, 32'h0000_0010, 'h20a);
        put_desc('h020, 'h030, 'h240, 32'h0000_0018, 'h240);
        put_desc('h030, 'h3f0, 'h281, 32'h1234_0009, 'h28b);
        expect_desc('h010);
        expect_desc('h020);
        expect_desc('h030);
        rdy_mode = 1;
        i0 = irq_cnt;
        pulse_start('h010);
        repeat (15) @(posedge clk);
        pulse_start('h000);   // R12: ignored while busy
        wait_eol("R9 chain reaches end of list");
        chk(irq_cnt - i0 == 2, "R6 R10 irq count over chain", irq_cnt - i0, 2);
        chk(wr_log.size() == 12 && wr_log[8][63:32] == 32'h030, "R9 third descriptor followed", wr_log.size(), 12);
        chk(wr_log.size() == 12 && wr_log[4][63:32] == 32'h020, "R10 empty descriptor closed", wr_log.size(), 12);
        check_wb("R7 write-back over chain");

        // Continue with end-of-list still set: stays halted.
        rdy_mode = 0;
        i0 = irq_cnt; b0 = byte_cnt;
        pulse_cont();
        repeat (40) @(negedge clk);
        chk(eol === 1'b1 && byte_cnt == b0, "R11 continue with eol set stays halted", byte_cnt - b0, 0);
        chk(wr_log.size() == 0, "R11 re-read writes nothing", wr_log.size(), 0);

        // Continue after clearing end-of-list: follow next pointer.
        mem[('h030 >> 2) + 0] = 32'h040;
        mem[('h030 >> 2) + 2] = 32'h1234_0008;
        put_desc('h040, 'h3f0, 'h300, 32'h0000_0019, 'h306);
        expect_desc('h040);
        pulse_cont();
        begin
            int n = 0;
            while (eol !== 1'b0 && n < 40) begin @(negedge clk); n++; end
            chk(n < 40, "R11 eol falls on resume", eol, 0);
        end
        wait_eol("R11 resumed descriptor completes");
        check_wb("R11 only resumed descriptor written back");
        chk(irq_cnt - i0 == 1, "R6 irq on resumed descriptor", irq_cnt - i0, 1);

        // Run gating and step limit.
        run = 1'b0;
        put_desc('h050, 'h3f0, 'h340, 32'h0000_0001, 'h34b);
        expect_desc('h050);
        b0 = byte_cnt;
        pulse_start('h050);
        repeat (40) @(negedge clk);
        chk(byte_cnt == b0 && st_valid === 1'b0, "R4 no step while not running", byte_cnt - b0, 0);
        @(posedge clk); #1;
        rdy_man = 1'b0;
        run = 1'b1;
        begin
            int n = 0;
            while (st_valid !== 1'b1 && n < 40) begin @(negedge clk); n++; end
        end
        @(posedge clk); #1;
        run = 1'b0;
        rdy_man = 1'b1;
        repeat (40) @(negedge clk);
        chk(byte_cnt - b0 == STEP, "R4 begun step completes then halts", byte_cnt - b0, STEP);
        run = 1'b1;
        wait_eol("R4 remaining steps complete");
        chk(byte_cnt - b0 == 11, "R4 total bytes of long buffer", byte_cnt - b0, 11);
        check_wb("R7 write-back of long buffer");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule